// File: doc/BRIEF.md
# Interrupt Request Arbiter Core

This block captures up to eight interrupt request lines and decides which of them, if any, should interrupt the processor now. Each line is latched into a pending register, either on a rising edge or by following its level, as chosen per line by a sense-select vector. Lines whose sense-select bit is not implemented in hardware always behave as edge-sensitive.

The pending bits that the mask leaves visible form the candidate set. A rotating search picks the winner: it starts at the line given by the rotation base and wraps around, so the base line has the highest priority. The winner's search distance is then compared with the distance of the highest-priority line already in service. The interrupt output is raised only when the candidate is strictly more urgent. On a cascade master, the in-service bit of the cascade input can be left out of that comparison so that a nested request from a downstream controller can still get through.

Programming the mask, rotation and in-service state, and the acknowledge handshake, belong to surrounding logic. This core receives them as inputs.

Top module: `irq_arbiter_core`

## Requirements
- R1: On an edge-sensitive line, the pending bit is set on the clock after the line is sampled high following a low sample. It is not cleared when the line falls or stays high. The stored previous level resets to low, so a line that is high when reset ends counts as a rising edge.
- R2: On a level-sensitive line (sense_sel bit = 1 and implemented), the pending bit equals the line level sampled at the previous clock edge.
- R3: Sense-select bits outside TRIG_IMPL are treated as 0 (edge). With the default TRIG_IMPL = 8'hF8, lines 0 to 2 are always edge-sensitive.
- R4: The candidate set is pending AND NOT mask_in (mask bit = 1 hides the line). win_valid is 1 exactly when the candidate set is non-empty.
- R5: Search step s examines line (s + rot_base) mod 8, and the lowest step holding a candidate wins. win_idx is that line number, or 0 when win_valid is 0.
- R6: irq_out is 1 only when the winning candidate's step is strictly less than the lowest step that holds an in_service bit. An empty in-service set counts as step 8.
- R7: With IS_MASTER set and nest_excl = 1, in_service bit CASC_POS (default 2) is ignored in the R6 comparison.
- R8: The outputs respond within the same cycle to changes on mask_in, in_service, rot_base and nest_excl. Changes on req_in reach the outputs only after the next clock edge.
- R9: While rst_n is low at a clock edge, the pending bits and stored levels are cleared, so win_valid, win_idx and irq_out are 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_in | input | N | Interrupt request lines |
| mask_in | input | N | 1 hides the line from arbitration |
| sense_sel | input | N | 1 = level-sensitive, 0 = edge-sensitive |
| in_service | input | N | Lines currently being serviced |
| rot_base | input | log2(N) | Line that has the highest priority |
| nest_excl | input | 1 | Ignore the cascade in-service bit when computing current priority |
| win_idx | output | log2(N) | Winning line number |
| win_valid | output | 1 | A candidate exists |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The bench uses the default parameters: eight lines, TRIG_IMPL = 8'hF8, the cascade input at line 2 and the master variant. With these values, the forced-edge behaviour of the low three lines can be seen at the ports, because a line programmed level-sensitive keeps its pending bit after it falls. The cascade exclusion is active, so a request can win against an in-service bit 2 only while nest_excl is set. Every rotation base can be reached, so the vectors include wrap-around searches in which a numerically lower line loses to a higher one.

// File: rtl/irq_arb_pkg.sv
// Package: shared types for the interrupt request arbiter.
// Assumes nothing beyond IEEE 1800-2017 packages.
package irq_arb_pkg;

    // How one request line is latched into its pending bit.
    typedef enum logic {
        SENSE_EDGE  = 1'b0,
        SENSE_LEVEL = 1'b1
    } sense_e;

    // Default number of request lines handled by one core.
    localparam int unsigned LINES_DFLT = 8;

endpackage

// File: rtl/irq_line_capture.sv
// Module: irq_line_capture
// Latches one request line into a pending bit. In edge mode, a low-to-high
// change against the stored previous level sets the bit, and the bit then
// holds. In level mode, the bit copies the line. Assumes req is synchronous
// to clk.
module irq_line_capture
    import irq_arb_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   req,
    input  sense_e mode,
    output logic   pend
);

    logic prev_q;

    // Store the line level so that edges can be detected on the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= req;
    end

    // Update the pending bit according to the sense mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
        end else begin
            unique case (mode)
                SENSE_LEVEL: pend <= req;
                SENSE_EDGE:  if (req && !prev_q) pend <= 1'b1;
                default:     pend <= pend;
            endcase
        end
    end

endmodule

// File: rtl/irq_step_search.sv
// Module: irq_step_search
// Rotating find-first. It returns the smallest step s for which
// vec[(s + rot) mod N] is set, or N when vec is empty. Assumes N is a power
// of two so that the wrap is a plain truncation. Purely combinational.
module irq_step_search #(
    parameter int unsigned N = 8,
    localparam int unsigned W = $clog2(N)
) (
    input  logic [N-1:0] vec,
    input  logic [W-1:0] rot,
    output logic [W:0]   step,
    output logic         found
);

    logic [N-1:0] rv;

    // Rotate the vector so that rv[0] is the line at the rotation base.
    for (genvar s = 0; s < N; s++) begin : g_rot
        localparam logic [W-1:0] S = W'(s);
        assign rv[s] = vec[S + rot];
    end

    // Find the lowest set step, scanning from the lowest priority upward.
    always_comb begin
        step  = (W+1)'(N);
        found = |rv;
        for (int s = N - 1; s >= 0; s--) begin
            if (rv[s]) step = (W+1)'(s);
        end
    end

endmodule

// File: rtl/irq_arbiter_core.sv
// Module: irq_arbiter_core
// Captures N request lines, hides masked ones, and picks the
// highest-priority pending line with a rotating search. It raises irq_out
// when that line is more urgent than the most urgent line in service.
// Assumes N is a power of two. Sense-select bits outside TRIG_IMPL do not
// exist in hardware and force edge mode.
module irq_arbiter_core
    import irq_arb_pkg::*;
#(
    parameter int unsigned N         = LINES_DFLT,
    parameter logic [N-1:0] TRIG_IMPL = 8'hF8,
    parameter int unsigned CASC_POS  = 2,
    parameter bit          IS_MASTER = 1'b1,
    localparam int unsigned W = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_in,
    input  logic [N-1:0] mask_in,
    input  logic [N-1:0] sense_sel,
    input  logic [N-1:0] in_service,
    input  logic [W-1:0] rot_base,
    input  logic         nest_excl,
    output logic [W-1:0] win_idx,
    output logic         win_valid,
    output logic         irq_out
);

    localparam logic [N-1:0] EXCL_MASK = {{(N-1){1'b0}}, 1'b1} << CASC_POS;

    logic [N-1:0] pend_q;
    logic [N-1:0] cand;
    logic [N-1:0] isr_eff;
    logic [W:0]   p_step;
    logic [W:0]   c_step;
    logic         p_found;
    logic         c_found;

    // One capture cell per line; unimplemented sense bits are tied to edge.
    for (genvar i = 0; i < N; i++) begin : g_line
        sense_e mode_i;
        assign mode_i = (TRIG_IMPL[i] && sense_sel[i]) ? SENSE_LEVEL : SENSE_EDGE;
        irq_line_capture u_cap (
            .clk  (clk),
            .rst_n(rst_n),
            .req  (req_in[i]),
            .mode (mode_i),
            .pend (pend_q[i])
        );
    end

    // Candidates are the pending lines that the mask leaves visible.
    assign cand = pend_q & ~mask_in;

    // Master variant can drop the cascade in-service bit from the comparison.
    if (IS_MASTER) begin : g_master
        assign isr_eff = nest_excl ? (in_service & ~EXCL_MASK) : in_service;
    end else begin : g_slave
        logic unused_nest;
        assign unused_nest = nest_excl;
        assign isr_eff     = in_service;
    end

    irq_step_search #(.N(N)) u_pend_search (
        .vec  (cand),
        .rot  (rot_base),
        .step (p_step),
        .found(p_found)
    );

    irq_step_search #(.N(N)) u_isr_search (
        .vec  (isr_eff),
        .rot  (rot_base),
        .step (c_step),
        .found(c_found)
    );

    // Turn the winning step into a line number and compare it with the in-service step.
    always_comb begin
        win_valid = p_found;
        win_idx   = p_found ? (p_step[W-1:0] + rot_base) : '0;
        irq_out   = p_found && (c_found ? (p_step < c_step) : 1'b1);
    end

endmodule

// File: rtl/irq_arbiter_checks.sv
// Module: irq_arbiter_checks
// Property checks for irq_arbiter_core, attached with bind. Assumes the
// same parameters as the core.
module irq_arbiter_checks #(
    parameter int unsigned N         = 8,
    parameter logic [N-1:0] TRIG_IMPL = 8'hF8,
    parameter int unsigned CASC_POS  = 2,
    parameter bit          IS_MASTER = 1'b1,
    localparam int unsigned W = $clog2(N)
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] req_in,
    input logic [N-1:0] mask_in,
    input logic [N-1:0] sense_sel,
    input logic [N-1:0] in_service,
    input logic         nest_excl,
    input logic [N-1:0] pend_q,
    input logic [W-1:0] win_idx,
    input logic         win_valid,
    input logic         irq_out
);

    for (genvar i = 0; i < N; i++) begin : g_chk
        logic lvl;
        assign lvl = sense_sel[i] && TRIG_IMPL[i];

        // R1: a rising edge on an edge-sensitive line sets its pending bit.
        assert_edge_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (!lvl && req_in[i] && !$past(req_in[i])) |=> pend_q[i]);

        // R3: an edge-sensitive (or forced-edge) pending bit never drops.
        assert_edge_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (!lvl && pend_q[i]) |=> pend_q[i]);

        // R2: a level-sensitive pending bit tracks the sampled line.
        assert_level_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
            lvl |=> (pend_q[i] == $past(req_in[i])));
    end

    // R4: win_valid only with a visible pending line.
    assert_valid_cand_R4: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> ((pend_q & ~mask_in) != '0));

    // R5: the winner is itself pending and unmasked.
    assert_win_unmasked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (pend_q[win_idx] && !mask_in[win_idx]));

    // R6: no interrupt without a candidate.
    assert_irq_needs_cand_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> win_valid);

    // R7: only the cascade bit in service cannot block a candidate when excluded.
    assert_cascade_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (IS_MASTER && nest_excl && win_valid &&
         (in_service == ({{(N-1){1'b0}}, 1'b1} << CASC_POS))) |-> irq_out);

    // R9: reset empties the pending register.
    assert_reset_clear_R9: assert property (@(posedge clk)
        !rst_n |=> (pend_q == '0));

endmodule

bind irq_arbiter_core irq_arbiter_checks #(
    .N(N), .TRIG_IMPL(TRIG_IMPL), .CASC_POS(CASC_POS), .IS_MASTER(IS_MASTER)
) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_in    (req_in),
    .mask_in   (mask_in),
    .sense_sel (sense_sel),
    .in_service(in_service),
    .nest_excl (nest_excl),
    .pend_q    (pend_q),
    .win_idx   (win_idx),
    .win_valid (win_valid),
    .irq_out   (irq_out)
);

// File: tb/tb_irq_arbiter_core.sv
`timescale 1ns/1ps
module tb_irq_arbiter_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req_in = '0, mask_in = '0, sense_sel = '0, in_service = '0;
    logic [2:0] rot_base = '0;
    logic       nest_excl = 1'b0;
    logic [2:0] win_idx;
    logic       win_valid, irq_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    irq_arbiter_core dut (
        .clk(clk), .rst_n(rst_n), .req_in(req_in), .mask_in(mask_in),
        .sense_sel(sense_sel), .in_service(in_service), .rot_base(rot_base),
        .nest_excl(nest_excl), .win_idx(win_idx), .win_valid(win_valid),
        .irq_out(irq_out)
    );

    typedef struct packed {
        logic [7:0] req;
        logic [7:0] msk;
        logic [7:0] isr;
        logic [2:0] rot;
        logic       nest;
        logic       v;
        logic [2:0] idx;
        logic       irq;
    } vec_t;

    // Level-sensitive lines 3..7 only, so no edge bit is ever latched here.
    localparam vec_t VECS [14] = '{
        '{8'h00, 8'h00, 8'h00, 3'd0, 1'b0, 1'b0, 3'd0, 1'b0},
        '{8'h08, 8'h00, 8'h00, 3'd0, 1'b0, 1'b1, 3'd3, 1'b1},
        '{8'h88, 8'h00, 8'h00, 3'd0, 1'b0, 1'b1, 3'd3, 1'b1},
        '{8'h88, 8'h00, 8'h00, 3'd4, 1'b0, 1'b1, 3'd7, 1'b1},
        '{8'h88, 8'h80, 8'h00, 3'd4, 1'b0, 1'b1, 3'd3, 1'b1},
        '{8'h88, 8'h88, 8'h00, 3'd0, 1'b0, 1'b0, 3'd0, 1'b0},
        '{8'h18, 8'h00, 8'h08, 3'd0, 1'b0, 1'b1, 3'd3, 1'b0},
        '{8'h10, 8'h00, 8'h20, 3'd0, 1'b0, 1'b1, 3'd4, 1'b1},
        '{8'h20, 8'h00, 8'h10, 3'd0, 1'b0, 1'b1, 3'd5, 1'b0},
        '{8'h40, 8'h00, 8'h04, 3'd0, 1'b0, 1'b1, 3'd6, 1'b0},
        '{8'h40, 8'h00, 8'h04, 3'd0, 1'b1, 1'b1, 3'd6, 1'b1},
        '{8'h40, 8'h00, 8'h06, 3'd0, 1'b1, 1'b1, 3'd6, 1'b0},
        '{8'h08, 8'h00, 8'h80, 3'd7, 1'b0, 1'b1, 3'd3, 1'b0},
        '{8'h08, 8'h00, 8'h02, 3'd2, 1'b0, 1'b1, 3'd3, 1'b1}
    };

    task automatic check(input string tag, input logic ev, input logic [2:0] ei,
                         input logic eq);
        n_chk++;
        if (win_valid !== ev || win_idx !== ei || irq_out !== eq) begin
            n_bad++;
            $display("FAIL %s: got valid=%0b idx=%0d irq=%0b, expected valid=%0b idx=%0d irq=%0b",
                     tag, win_valid, win_idx, irq_out, ev, ei, eq);
        end
    endtask

    task automatic do_reset(input logic [7:0] hold_req);
        @(negedge clk);
        rst_n = 1'b0; req_in = hold_req; mask_in = '0; in_service = '0;
        rot_base = '0; nest_excl = 1'b0; sense_sel = '0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #4000000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R9: reset with a line held high gives empty outputs.
        do_reset(8'h01);
        check("R9 during reset", 1'b0, 3'd0, 1'b0);
        rst_n = 1'b1;
        check("R9 just after reset", 1'b0, 3'd0, 1'b0);
        // R1: a line high when reset ends counts as a rising edge.
        @(negedge clk);
        check("R1 high across reset", 1'b1, 3'd0, 1'b1);

        // Table walk: priority, mask, rotation, nesting (R4 R5 R6 R7).
        do_reset(8'h00);
        rst_n = 1'b1;
        sense_sel = 8'hFF;
        foreach (VECS[k]) begin
            req_in = VECS[k].req; mask_in = VECS[k].msk; in_service = VECS[k].isr;
            rot_base = VECS[k].rot; nest_excl = VECS[k].nest;
            @(negedge clk);
            check($sformatf("R4/R5/R6/R7 vector %0d", k), VECS[k].v, VECS[k].idx, VECS[k].irq);
        end

        // R2: level line 5 clears once the line falls.
        req_in = 8'h20; mask_in = '0; in_service = '0; rot_base = '0; nest_excl = 1'b0;
        @(negedge clk);
        check("R2 level high", 1'b1, 3'd5, 1'b1);
        req_in = 8'h00;
        @(negedge clk);
        check("R2 level low clears", 1'b0, 3'd0, 1'b0);

        // R8: mask and in-service act in the same cycle, req only after an edge.
        req_in = 8'h08;
        @(negedge clk);
        #2 mask_in = 8'h08;
        #2 check("R8 mask same cycle", 1'b0, 3'd0, 1'b0);
        mask_in = 8'h00; in_service = 8'h01;
        #2 check("R8 in-service same cycle", 1'b1, 3'd3, 1'b0);
        in_service = 8'h00; req_in = 8'h10;
        #2 check("R8 req waits for clock", 1'b1, 3'd3, 1'b1);
        @(negedge clk);
        check("R8 req after clock", 1'b1, 3'd4, 1'b1);

        // R3: line 1 is forced edge even when programmed level; falling keeps it.
        do_reset(8'h00);
        rst_n = 1'b1; sense_sel = 8'hFF;
        req_in = 8'h02;
        @(negedge clk);
        check("R3 forced edge set", 1'b1, 3'd1, 1'b1);
        req_in = 8'h00;
        @(negedge clk);
        check("R3 forced edge holds after fall", 1'b1, 3'd1, 1'b1);

        // R1: an implemented line in edge mode keeps its pending bit after falling.
        do_reset(8'h00);
        rst_n = 1'b1; sense_sel = 8'h00;
        req_in = 8'h40;
        @(negedge clk);
        req_in = 8'h40;
        @(negedge clk);
        check("R1 edge steady high", 1'b1, 3'd6, 1'b1);
        req_in = 8'h00;
        @(negedge clk);
        check("R1 edge holds after fall", 1'b1, 3'd6, 1'b1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule